// File: doc/BRIEF.md
# Serial Monitor Command Port

This block is a slow serial management port. A host uses it to reach a bank of internal application registers and a sticky status register. While a select line is high, the host shifts a 25-bit instruction word in, one bit per rising edge of a serial clock. When select drops, the block checks the word for odd parity, decodes its 3-bit opcode and executes the command. It then loads a 25-bit response word. The host shifts that response out during its next select window, at the same time as it shifts the next instruction in.

The serial clock, data, select and mode inputs all come from outside the system clock domain. Each passes through a two-stage synchronizer, and clock and select edges are detected in the system domain. The serial clock must run at no more than half the system clock rate. When the mode input is low, the port is in scan-string operation: it neither shifts nor executes, because scan operation is handled elsewhere. The application registers are exposed to the surrounding logic as one flat output vector.

Top module: `smon_port`

## Requirements
- R1: After reset the application registers, the status register and the response word are all zero, so the serial output is 0.
- R2: Word bits are numbered 0 to 24 and shifted in from bit 24 down to bit 0, so the parity bit 0 arrives last. Bits 1..3 hold the opcode, bits 4..11 the address and bits 12..24 the data field. In every field the lowest-numbered bit is the most significant. The response shifts out in the same order on the same clock edges.
- R3: A word whose 25 bits do not have odd parity executes nothing. It sets status bit 0, and its response data field returns the updated status.
- R4: Opcode 000 returns the status register in the data field and leaves the status unchanged.
- R5: Opcode 001 returns the instruction's data field unchanged and has no other effect.
- R6: Opcode 010 writes the data field into the register at the given address, when that address is below NREG. The response returns the data field.
- R7: Opcode 011 returns the addressed register in the data field. A read or write at an address of NREG or more changes no register, returns data 0 on a read, and sets status bit 2.
- R8: Opcode 100 returns the status register and then clears it to zero.
- R9: Opcodes 101, 110 and 111 change no register, return data 0 and set status bit 1.
- R10: The response word repeats the instruction's opcode and address bits. Its data field carries the result, and bit 0 makes the whole response word odd parity.
- R11: While the mode input is low, serial clock edges shift nothing and releasing select executes nothing.
- R12: Registers and status change only in the system cycle in which a command executes, which follows the detected release of select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mon_sclk | input | 1 | Serial shift clock, asynchronous, at most half the clk rate |
| mon_sel | input | 1 | Select, high while a word is shifted |
| mon_din | input | 1 | Serial instruction data |
| mon_mode | input | 1 | 1 = instruction/status operation, 0 = scan-string operation |
| mon_dout | output | 1 | Serial response data |
| app_regs | output | NREG*13 | Application registers, register i at bits [i*13 +: 13] |

## Verification
Some properties are checked on every cycle. Registers and status move only in an execution cycle. The instruction shift register holds still between detected shift edges. Every loaded response word has odd parity. Execution happens only while instruction mode is active. What only the bench scenarios can show is the command meaning, carried end to end through the serial protocol: decode of each opcode and the parity rejection, status that persists across a NOOP and clears on a status read, out-of-range addresses, and the fact that a scan-mode window leaves every register and the pending response untouched.

// File: rtl/smon_pkg.sv
// Shared constants and field helpers for the serial monitor port.
// Assumes word bit k is stored at vector index k, with the lowest
// numbered bit of every field being its most significant bit.
package smon_pkg;
    localparam int WORD_W  = 25;
    localparam int OP_W    = 3;
    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 13;
    localparam int OP_LO   = 1;
    localparam int ADDR_LO = OP_LO + OP_W;
    localparam int DATA_LO = ADDR_LO + ADDR_W;

    localparam int ST_PAR = 0;
    localparam int ST_ILL = 1;
    localparam int ST_RNG = 2;

    localparam logic [OP_W-1:0] OP_NOOP  = 3'b000;
    localparam logic [OP_W-1:0] OP_ECHO  = 3'b001;
    localparam logic [OP_W-1:0] OP_WRITE = 3'b010;
    localparam logic [OP_W-1:0] OP_READ  = 3'b011;
    localparam logic [OP_W-1:0] OP_RSTAT = 3'b100;

    // Extract the opcode, MSB at the lowest word bit.
    function automatic logic [OP_W-1:0] get_op(input logic [WORD_W-1:0] w);
        logic [OP_W-1:0] r;
        for (int i = 0; i < OP_W; i++) r[OP_W-1-i] = w[OP_LO+i];
        return r;
    endfunction

    // Extract the address field.
    function automatic logic [ADDR_W-1:0] get_addr(input logic [WORD_W-1:0] w);
        logic [ADDR_W-1:0] r;
        for (int i = 0; i < ADDR_W; i++) r[ADDR_W-1-i] = w[ADDR_LO+i];
        return r;
    endfunction

    // Extract the data field.
    function automatic logic [DATA_W-1:0] get_data(input logic [WORD_W-1:0] w);
        logic [DATA_W-1:0] r;
        for (int i = 0; i < DATA_W; i++) r[DATA_W-1-i] = w[DATA_LO+i];
        return r;
    endfunction

    // Build a response: instruction word with a new data field and odd parity.
    function automatic logic [WORD_W-1:0] mk_resp(input logic [WORD_W-1:0] w,
                                                  input logic [DATA_W-1:0] d);
        logic [WORD_W-1:0] r;
        r = w;
        for (int i = 0; i < DATA_W; i++) r[DATA_LO+i] = d[DATA_W-1-i];
        r[0] = ~^r[WORD_W-1:1];
        return r;
    endfunction
endpackage

// File: rtl/smon_sync.sv
// Multi-bit two-stage synchronizer. Each bit is treated independently;
// assumes inputs are slow relative to clk, so no bus coherency is needed.
module smon_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    // Two flops in series toward the system domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/smon_shift.sv
// Instruction and response shift registers. On a shift pulse the new bit
// enters at index 0 and the response moves toward index W-1, which drives
// the serial output. A load has priority over a shift.
module smon_shift #(
    parameter int W = 25
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         din,
    input  logic         load_en,
    input  logic [W-1:0] load_word,
    output logic [W-1:0] ir_q,
    output logic         dout
);
    logic [W-1:0] resp_q;

    // Instruction register: shift the sampled data bit in.
    always_ff @(posedge clk) begin
        if (!rst_n)        ir_q <= '0;
        else if (shift_en) ir_q <= {ir_q[W-2:0], din};
    end

    // Response register: load after execution, otherwise shift out.
    always_ff @(posedge clk) begin
        if (!rst_n)        resp_q <= '0;
        else if (load_en)  resp_q <= load_word;
        else if (shift_en) resp_q <= {resp_q[W-2:0], 1'b0};
    end

    assign dout = resp_q[W-1];
endmodule

// File: rtl/smon_exec.sv
// Command decoder and executor with the application register bank and the
// sticky status register. Acts only on a one-cycle go pulse. Assumes NREG
// is a power of two, at least 2, and no larger than 2**ADDR_W.
module smon_exec
    import smon_pkg::*;
#(
    parameter int NREG = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     go,
    input  logic [WORD_W-1:0]        word,
    output logic [WORD_W-1:0]        resp_word,
    output logic                     resp_vld,
    output logic [NREG*DATA_W-1:0]   app_flat,
    output logic [DATA_W-1:0]        stat_q
);
    localparam int IDX_W = $clog2(NREG);

    logic [OP_W-1:0]   op;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic [IDX_W-1:0]  idx;
    logic              par_ok;
    logic              in_range;
    logic              wr_en;
    logic [DATA_W-1:0] rdata;
    logic [DATA_W-1:0] rd_reg;
    logic [DATA_W-1:0] stat_n;

    assign op       = get_op(word);
    assign addr     = get_addr(word);
    assign data     = get_data(word);
    assign idx      = addr[IDX_W-1:0];
    assign par_ok   = ^word;
    assign in_range = (addr[ADDR_W-1:IDX_W] == '0);

    // Select the addressed register for a read.
    always_comb begin
        rd_reg = app_flat[idx*DATA_W +: DATA_W];
    end

    // Decode the command into a result, a write enable and the next status.
    always_comb begin
        stat_n = stat_q;
        rdata  = '0;
        wr_en  = 1'b0;
        if (!par_ok) begin
            stat_n[ST_PAR] = 1'b1;
            rdata          = stat_n;
        end else begin
            case (op)
                OP_NOOP:  rdata = stat_q;
                OP_ECHO:  rdata = data;
                OP_WRITE: begin
                    rdata = data;
                    if (in_range) wr_en = 1'b1;
                    else          stat_n[ST_RNG] = 1'b1;
                end
                OP_READ: begin
                    if (in_range) rdata = rd_reg;
                    else          stat_n[ST_RNG] = 1'b1;
                end
                OP_RSTAT: begin
                    rdata  = stat_q;
                    stat_n = '0;
                end
                default:  stat_n[ST_ILL] = 1'b1;
            endcase
        end
    end

    // Status update and response capture on execution.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q    <= '0;
            resp_word <= '0;
            resp_vld  <= 1'b0;
        end else begin
            resp_vld <= go;
            if (go) begin
                stat_q    <= stat_n;
                resp_word <= mk_resp(word, rdata);
            end
        end
    end

    // One storage word per application register.
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [DATA_W-1:0] r_q;

        // Write the data field when this register is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)                                   r_q <= '0;
            else if (go && wr_en && idx == IDX_W'(g))      r_q <= data;
        end

        assign app_flat[g*DATA_W +: DATA_W] = r_q;
    end
endmodule

// File: rtl/smon_port.sv
// Serial monitor command port top. Synchronizes the serial pins, detects
// rising shift-clock edges and the release of select, and runs one command
// the cycle after each release. Assumes mon_sclk is at most half the clk rate.
module smon_port
    import smon_pkg::*;
#(
    parameter int NREG = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   mon_sclk,
    input  logic                   mon_sel,
    input  logic                   mon_din,
    input  logic                   mon_mode,
    output logic                   mon_dout,
    output logic [NREG*DATA_W-1:0] app_regs
);
    logic [3:0]        sync_q;
    logic              mode_s, sel_s, sclk_s, din_s;
    logic              sclk_d, sel_d;
    logic              shift_en, sel_fall, go;
    logic [WORD_W-1:0] ir_q;
    logic [WORD_W-1:0] resp_word;
    logic              resp_vld;
    logic [DATA_W-1:0] stat_q;

    smon_sync #(.W(4)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({mon_mode, mon_sel, mon_sclk, mon_din}),
        .q     (sync_q)
    );

    assign {mode_s, sel_s, sclk_s, din_s} = sync_q;

    // Delayed copies for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            sel_d  <= 1'b0;
        end else begin
            sclk_d <= sclk_s;
            sel_d  <= sel_s;
        end
    end

    assign shift_en = sclk_s & ~sclk_d & sel_s & mode_s;
    assign sel_fall = sel_d & ~sel_s & mode_s;

    // Execution pulse one cycle after the detected release.
    always_ff @(posedge clk) begin
        if (!rst_n) go <= 1'b0;
        else        go <= sel_fall;
    end

    smon_shift #(.W(WORD_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (shift_en),
        .din       (din_s),
        .load_en   (resp_vld),
        .load_word (resp_word),
        .ir_q      (ir_q),
        .dout      (mon_dout)
    );

    smon_exec #(.NREG(NREG)) u_exec (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .word      (ir_q),
        .resp_word (resp_word),
        .resp_vld  (resp_vld),
        .app_flat  (app_regs),
        .stat_q    (stat_q)
    );
endmodule

// File: rtl/smon_port_chk.sv
// Cycle-level properties of the serial monitor port, bound into the top.
module smon_port_chk
    import smon_pkg::*;
#(
    parameter int NREG = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   go,
    input  logic                   shift_en,
    input  logic                   mode_s,
    input  logic                   resp_vld,
    input  logic [WORD_W-1:0]      ir_q,
    input  logic [WORD_W-1:0]      resp_word,
    input  logic [DATA_W-1:0]      stat_q,
    input  logic [NREG*DATA_W-1:0] app_regs
);
    // R12
    reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> $stable(app_regs));

    // R12
    stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> $stable(stat_q));

    // R2
    ir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(ir_q));

    // R11
    go_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> $past(mode_s));

    // R10
    resp_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_vld |-> ($countones(resp_word) % 2 == 1));
endmodule

bind smon_port smon_port_chk #(.NREG(NREG)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .shift_en  (shift_en),
    .mode_s    (mode_s),
    .resp_vld  (resp_vld),
    .ir_q      (ir_q),
    .resp_word (resp_word),
    .stat_q    (stat_q),
    .app_regs  (app_regs)
);

// File: tb/smon_port_bench.sv
module smon_port_bench;
    localparam int CLK_P = 10;
    localparam int NREG  = 8;
    localparam int DW    = 13;
    localparam int HALF  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mon_sclk = 1'b0, mon_sel = 1'b0, mon_din = 1'b0, mon_mode = 1'b1;
    logic mon_dout;
    logic [NREG*DW-1:0] app_regs;

    smon_port #(.NREG(NREG)) u_smon_port (
        .clk(clk), .rst_n(rst_n), .mon_sclk(mon_sclk), .mon_sel(mon_sel),
        .mon_din(mon_din), .mon_mode(mon_mode), .mon_dout(mon_dout),
        .app_regs(app_regs)
    );

    always #(CLK_P/2) clk = ~clk;

    int total = 0;
    int bad = 0;
    logic [DW-1:0] mregs [NREG];
    logic [DW-1:0] mstat;
    logic [24:0]   exp_prev;
    string         prev_tag;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Build an instruction word (R2 layout), with good or bad odd parity (R3).
    function automatic logic [24:0] mkw(input logic [2:0] op, input logic [7:0] a,
                                        input logic [DW-1:0] d, input bit good);
        logic [24:0] w = '0;
        for (int i = 0; i < 3; i++)  w[1+i]  = op[2-i];
        for (int i = 0; i < 8; i++)  w[4+i]  = a[7-i];
        for (int i = 0; i < DW; i++) w[12+i] = d[DW-1-i];
        w[0] = good ? ~^w[24:1] : ^w[24:1];
        return w;
    endfunction

    // Expected response per R3..R10, updating the model state.
    task automatic model(input logic [24:0] w, output logic [24:0] r);
        logic [2:0] op; logic [7:0] a; logic [DW-1:0] d, res;
        op = {w[1], w[2], w[3]};
        for (int i = 0; i < 8; i++)  a[7-i] = w[4+i];
        for (int i = 0; i < DW; i++) d[DW-1-i] = w[12+i];
        res = '0;
        if (^w == 1'b0) begin
            mstat[0] = 1'b1; res = mstat;
        end else if (op == 3'b000) res = mstat;
        else if (op == 3'b001) res = d;
        else if (op == 3'b010) begin
            res = d;
            if (a < NREG) mregs[a] = d; else mstat[2] = 1'b1;
        end else if (op == 3'b011) begin
            if (a < NREG) res = mregs[a]; else mstat[2] = 1'b1;
        end else if (op == 3'b100) begin
            res = mstat; mstat = '0;
        end else mstat[1] = 1'b1;
        r = w;
        for (int i = 0; i < DW; i++) r[12+i] = res[DW-1-i];
        r[0] = ~^r[24:1];
    endtask

    task automatic check_regs(input string tag);
        for (int i = 0; i < NREG; i++)
            chk(app_regs[i*DW +: DW] == mregs[i], tag, 32'(app_regs[i*DW +: DW]),
                32'(mregs[i]));
    endtask

    // One select window: shift w in (bit 24 first), capture the response.
    task automatic xfer(input logic [24:0] w, output logic [24:0] r);
        mon_sel = 1'b1;
        wait_cyc(HALF);
        for (int i = 24; i >= 0; i--) begin
            mon_din = w[i];
            wait_cyc(HALF);
            r[i] = mon_dout;
            mon_sclk = 1'b1;
            wait_cyc(HALF);
            mon_sclk = 1'b0;
        end
        wait_cyc(HALF);
        check_regs("R12 before release");
        mon_sel = 1'b0;
        wait_cyc(12);
    endtask

    task automatic cmd(input logic [24:0] w, input string tag);
        logic [24:0] got;
        xfer(w, got);
        chk(got == exp_prev, {prev_tag, " R2 R10 response"}, 32'(got), 32'(exp_prev));
        model(w, exp_prev);
        prev_tag = tag;
        check_regs({tag, " regs"});
    endtask

    initial begin
        logic [24:0] junk;
        int unsigned seed;
        seed = $urandom(32'd20240611);
        for (int i = 0; i < NREG; i++) mregs[i] = '0;
        mstat = '0;
        exp_prev = '0;
        prev_tag = "R1 reset";
        wait_cyc(6);
        rst_n = 1'b1;
        wait_cyc(4);
        chk(mon_dout == 1'b0, "R1 dout", 32'(mon_dout), 32'd0);
        chk(app_regs == '0, "R1 regs", 32'(app_regs[31:0]), 32'd0);

        cmd(mkw(3'b010, 8'd3, 13'h1ABC, 1), "R6 write");
        cmd(mkw(3'b010, 8'd7, 13'h0F0F, 1), "R6 write top");
        cmd(mkw(3'b011, 8'd3, 13'h0, 1), "R7 read");
        cmd(mkw(3'b001, 8'd5, 13'h0A5A, 1), "R5 echo");
        cmd(mkw(3'b010, 8'd2, 13'h1111, 0), "R3 bad parity");
        cmd(mkw(3'b000, 8'd0, 13'h0, 1), "R4 noop");
        cmd(mkw(3'b000, 8'd0, 13'h0, 1), "R4 noop keeps");
        cmd(mkw(3'b100, 8'd0, 13'h0, 1), "R8 read status");
        cmd(mkw(3'b000, 8'd0, 13'h0, 1), "R8 cleared");
        cmd(mkw(3'b101, 8'd1, 13'h1FFF, 1), "R9 reserved 5");
        cmd(mkw(3'b111, 8'd2, 13'h0001, 1), "R9 reserved 7");
        cmd(mkw(3'b010, 8'd200, 13'h0555, 1), "R7 write range");
        cmd(mkw(3'b011, 8'd9, 13'h0, 1), "R7 read range");
        cmd(mkw(3'b100, 8'd0, 13'h0, 1), "R8 status all");

        // R11: scan mode window, then show nothing changed.
        mon_mode = 1'b0;
        wait_cyc(4);
        xfer(mkw(3'b010, 8'd1, 13'h0777, 1), junk);
        mon_mode = 1'b1;
        wait_cyc(4);
        check_regs("R11 scan regs");
        cmd(mkw(3'b011, 8'd1, 13'h0, 1), "R11 read after scan");

        for (int n = 0; n < 150; n++) begin
            logic [2:0] op; logic [7:0] a; logic [DW-1:0] d; bit good;
            op = 3'($urandom % 8);
            a  = ($urandom % 4 == 0) ? 8'($urandom % 256) : 8'($urandom % NREG);
            d  = DW'($urandom);
            good = ($urandom % 10) != 0;
            if (op == 3'b000) begin a = '0; d = '0; end
            cmd(mkw(op, a, d, good), "R2 random");
        end
        cmd(mkw(3'b000, 8'd0, 13'h0, 1), "R4 final");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R12 watchdog act=timeout exp=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule